// File: doc/BRIEF.md
# Serial Flash Command Acceptance Front-End

This block sits behind the pins of a 1-Mbit serial flash and decides which host commands may run. It shifts in opcode, address and data on one serial input, most significant bit first, and counts serial clocks while chip select is low. When chip select rises it judges the frame. The judgement covers how many clocks arrived, whether the write-enable latch is set, whether an internal write cycle is busy, and whether the target address falls inside the region locked by the four block-protect bits. A frame that passes produces a one-cycle execute strobe carrying the opcode, address, data-byte count and last received byte. A frame that fails is dropped with no strobe.

Read-type commands are not judged at chip-select rise. Instead they raise a separate strobe as soon as their header is complete, so that output data can start. Their frame may then be cut after any bit without any error.

The serial pins are assumed to be already synchronous to `clk`. Serial clock edges are found by sampling. The array, the program and erase timers, and the multi-line I/O modes belong to other blocks.

Top module: `sf_cmd_front`

## Requirements
- R1: A bit is taken from `si` on each sampled rising edge of `sclk` while `cs_n` is low, MSB first. The first byte is the opcode and the next three bytes form the 24-bit address.
- R2: Write enable (06h), write disable (04h), chip erase (C7h) and deep power-down (B9h) execute only when the clock count since `cs_n` fell is a non-zero multiple of 8.
- R3: Page program (02h) needs a byte-aligned frame of at least 5 bytes. `cmd_nbytes` then equals the byte count minus 4. A shorter or unaligned frame does nothing and leaves `wel` unchanged.
- R4: Sector (20h), half-block (52h) and block (D8h) erase need exactly 32 clocks and report `cmd_nbytes` = 0. Any other count rejects the frame.
- R5: Status write (01h) needs exactly 16 clocks and reports the status byte on `cmd_data` with `cmd_nbytes` = 1.
- R6: Address bit 16 selects the array half. Protect code 0000 and code 1000 lock nothing. Code 0001 locks the upper half, code 1001 locks the lower half, and all other codes lock everything. A program or erase aimed at a locked address is dropped.
- R7: Chip erase is dropped while the protect code is anything other than 0000 or 1000.
- R8: Write enable sets `wel` and write disable clears it. Program, erase and status write need `wel` = 1, and once accepted they clear it.
- R9: When `busy` is high in the cycle where `cs_n` is first seen high, no command executes. Array reads (03h, 0Bh) give no read strobe while `busy` is high. Status read (05h) and ID read (9Fh) still do.
- R10: `rd_req` pulses one cycle after the last header bit of a read: the opcode for 05h and 9Fh, the third address byte for 03h and 0Bh. Cutting a read frame anywhere gives no `cmd_valid` and leaves `wel` unchanged.
- R11: `cmd_valid` is a one-cycle pulse in the cycle after the clock edge at which `cs_n` is first sampled high. It never coincides with `rd_req`. After reset `wel` is 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled |
| si | input | 1 | Serial data in |
| busy | input | 1 | Internal write/program/erase cycle in progress |
| bp | input | 4 | Block-protect code |
| cmd_valid | output | 1 | Execute strobe |
| rd_req | output | 1 | Read header complete strobe |
| cmd_op | output | 8 | Opcode of the strobed command |
| cmd_addr | output | 24 | Address (0 for commands without one) |
| cmd_nbytes | output | CNT_W | Data bytes after the header |
| cmd_data | output | 8 | Last complete byte of the frame |
| wel | output | 1 | Write-enable latch |

## Verification
Two things are decided in the same cycle: the frame-end judgement, and the sampling of `busy` and `bp` that gate it. The bench raises `busy` on exactly the clock where `cs_n` goes high, after a frame that would otherwise be accepted. It expects no strobe and an unchanged latch. It also switches the protect code between frames and checks that the lock region is the one in force at the frame's end. Each expected strobe is predicted from the frame's clock count, the latch model and the lock rules, and is compared field by field when it appears.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_HBE  = 8'h52;
  localparam logic [7:0] OP_BE   = 8'h D8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RDID = 8'h9F;

  // lock decision for one half of the array
  function automatic logic half_locked(input logic [3:0] code, input logic upper);
    case (code)
      4'b0000, 4'b1000: half_locked = 1'b0;
      4'b0001:          half_locked = upper;
      4'b1001:          half_locked = ~upper;
      default:          half_locked = 1'b1;
    endcase
  endfunction

  function automatic logic any_locked(input logic [3:0] code);
    any_locked = !(code == 4'b0000 || code == 4'b1000);
  endfunction

  function automatic logic needs_latch(input logic [7:0] op);
    needs_latch = (op == OP_PP) || (op == OP_SE) || (op == OP_HBE) ||
                  (op == OP_BE) || (op == OP_CE) || (op == OP_WRSR);
  endfunction

  function automatic logic is_erase(input logic [7:0] op);
    is_erase = (op == OP_SE) || (op == OP_HBE) || (op == OP_BE);
  endfunction
endpackage

// File: rtl/sf_deser.sv
module sf_deser #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             si,
  output logic             byte_done,
  output logic [7:0]       next_byte,
  output logic [2:0]       bit_ph,
  output logic [CNT_W-1:0] byte_cnt,
  output logic [7:0]       opcode,
  output logic [23:0]      addr,
  output logic [7:0]       last_byte
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(4);

  logic       sclk_q;
  logic [6:0] sh;
  logic       sclk_rise;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign next_byte = {sh, si};
  assign byte_done = sclk_rise && (bit_ph == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      sh        <= '0;
      bit_ph    <= '0;
      byte_cnt  <= '0;
      opcode    <= '0;
      addr      <= '0;
      last_byte <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        sh        <= '0;
        bit_ph    <= '0;
        byte_cnt  <= '0;
        opcode    <= '0;
        addr      <= '0;
        last_byte <= '0;
      end else if (sclk_rise) begin
        sh     <= next_byte[6:0];
        bit_ph <= bit_ph + 3'd1;
        if (bit_ph == 3'd7) begin
          last_byte <= next_byte;
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0) opcode <= next_byte;
          else if (byte_cnt < HDR_END) addr <= {addr[15:0], next_byte};
        end
      end
    end
  end
endmodule

// File: rtl/sf_guard.sv
module sf_guard #(
  parameter int MEM_AW = 17
) (
  input  logic [3:0]  bp,
  input  logic [7:0]  op,
  input  logic [23:0] addr,
  output logic        lock_hit
);
  import sf_pkg::*;
  logic upper;
  assign upper = addr[MEM_AW-1];

  always_comb begin
    if (op == OP_CE)                        lock_hit = any_locked(bp);
    else if (op == OP_PP || is_erase(op))   lock_hit = half_locked(bp, upper);
    else                                    lock_hit = 1'b0;
  end
endmodule

// File: rtl/sf_cmd_front.sv
module sf_cmd_front #(
  parameter int CNT_W  = 10,
  parameter int MEM_AW = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             si,
  input  logic             busy,
  input  logic [3:0]       bp,
  output logic             cmd_valid,
  output logic             rd_req,
  output logic [7:0]       cmd_op,
  output logic [23:0]      cmd_addr,
  output logic [CNT_W-1:0] cmd_nbytes,
  output logic [7:0]       cmd_data,
  output logic             wel
);
  import sf_pkg::*;
  localparam logic [CNT_W-1:0] N1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] N2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] N3 = CNT_W'(3);
  localparam logic [CNT_W-1:0] N4 = CNT_W'(4);
  localparam logic [CNT_W-1:0] N5 = CNT_W'(5);

  logic             byte_done;
  logic [7:0]       next_byte;
  logic [2:0]       bit_ph;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       opcode;
  logic [23:0]      addr;
  logic [7:0]       last_byte;
  logic             lock_hit;

  sf_deser #(.CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .byte_done(byte_done), .next_byte(next_byte), .bit_ph(bit_ph),
    .byte_cnt(byte_cnt), .opcode(opcode), .addr(addr), .last_byte(last_byte)
  );

  sf_guard #(.MEM_AW(MEM_AW)) u_guard (
    .bp(bp), .op(opcode), .addr(addr), .lock_hit(lock_hit)
  );

  // named events for the checker
  logic cs_q, frame_end, aligned, len_ok, run, rd_now;
  logic [CNT_W-1:0] run_nb;
  logic [23:0]      run_addr;

  assign frame_end = cs_n & ~cs_q;
  assign aligned   = (bit_ph == 3'd0) && (byte_cnt != '0);

  always_comb begin
    len_ok   = 1'b0;
    run_nb   = '0;
    run_addr = '0;
    case (opcode)
      OP_WREN, OP_WRDI, OP_DP, OP_CE: len_ok = aligned;
      OP_WRSR: begin len_ok = aligned && byte_cnt == N2; run_nb = N1; end
      OP_PP: begin
        len_ok   = aligned && byte_cnt >= N5;
        run_nb   = byte_cnt - N4;
        run_addr = addr;
      end
      OP_SE, OP_HBE, OP_BE: begin
        len_ok   = aligned && byte_cnt == N4;
        run_addr = addr;
      end
      default: len_ok = 1'b0;
    endcase
  end

  assign run = frame_end && len_ok && !busy && !lock_hit &&
               (!needs_latch(opcode) || wel);

  assign rd_now = byte_done &&
                  ((byte_cnt == '0 && (next_byte == OP_RDSR || next_byte == OP_RDID)) ||
                   (byte_cnt == N3 && (opcode == OP_READ || opcode == OP_FAST) && !busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      cmd_valid  <= 1'b0;
      rd_req     <= 1'b0;
      cmd_op     <= '0;
      cmd_addr   <= '0;
      cmd_nbytes <= '0;
      cmd_data   <= '0;
      wel        <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      cmd_valid <= run;
      rd_req    <= rd_now;
      if (run) begin
        cmd_op     <= opcode;
        cmd_addr   <= run_addr;
        cmd_nbytes <= run_nb;
        cmd_data   <= last_byte;
        if (opcode == OP_WREN) wel <= 1'b1;
        else if (opcode == OP_WRDI || needs_latch(opcode)) wel <= 1'b0;
      end else if (rd_now) begin
        cmd_op     <= (byte_cnt == '0) ? next_byte : opcode;
        cmd_addr   <= (byte_cnt == '0) ? 24'h0 : {addr[15:0], next_byte};
        cmd_nbytes <= '0;
        cmd_data   <= next_byte;
      end
    end
  end
endmodule

// File: rtl/sf_cmd_front_chk.sv
module sf_cmd_front_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             busy,
  input logic [3:0]       bp,
  input logic             cmd_valid,
  input logic             rd_req,
  input logic [7:0]       cmd_op,
  input logic [CNT_W-1:0] cmd_nbytes,
  input logic             wel,
  input logic             frame_end,
  input logic             byte_done
);
  import sf_pkg::*;

  // R11
  strobe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_n) && $past(frame_end));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, rd_req}));
  // R8
  latch_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && needs_latch(cmd_op) |-> $past(wel));
  // R8
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && needs_latch(cmd_op) |-> !wel);
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(busy));
  // R7
  ce_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_CE |-> ($past(bp) == 4'b0000 || $past(bp) == 4'b1000));
  // R4
  erase_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_erase(cmd_op) |-> cmd_nbytes == '0);
  // R10
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(byte_done) && !$past(cs_n));
endmodule

bind sf_cmd_front sf_cmd_front_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .bp(bp),
  .cmd_valid(cmd_valid), .rd_req(rd_req), .cmd_op(cmd_op),
  .cmd_nbytes(cmd_nbytes), .wel(wel), .frame_end(frame_end),
  .byte_done(byte_done)
);

// File: tb/tb_sf_cmd_front.sv
module tb_sf_cmd_front;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0, busy = 1'b0;
  logic [3:0] bp = 4'b0000;
  logic cmd_valid, rd_req, wel;
  logic [7:0] cmd_op, cmd_data;
  logic [23:0] cmd_addr;
  logic [CNT_W-1:0] cmd_nbytes;

  sf_cmd_front #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .busy(busy), .bp(bp), .cmd_valid(cmd_valid), .rd_req(rd_req),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
    .cmd_data(cmd_data), .wel(wel)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic             rd;
    logic [7:0]       op;
    logic [23:0]      addr;
    logic [CNT_W-1:0] nb;
    logic [7:0]       dat;
    logic [7:0]       req;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  logic m_wel = 1'b0;
  logic [7:0] tx [0:7];

  // monitor: pops and compares as strobes appear
  always @(negedge clk) begin
    if (rst_n && (cmd_valid || rd_req)) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected strobe: actual op=%h addr=%h rd=%0d, expected none", cmd_op, cmd_addr, rd_req);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (e.rd != rd_req || e.op != cmd_op || e.addr != cmd_addr ||
            (!e.rd && (e.nb != cmd_nbytes || e.dat != cmd_data))) begin
          n_bad++;
          $display("FAIL R%0d: actual rd=%0d op=%h addr=%h nb=%0d dat=%h, expected rd=%0d op=%h addr=%h nb=%0d dat=%h",
                   e.req, rd_req, cmd_op, cmd_addr, cmd_nbytes, cmd_data,
                   e.rd, e.op, e.addr, e.nb, e.dat);
        end
      end
    end
  end

  function automatic logic m_lock(input logic [3:0] c, input logic [23:0] a);
    if (c == 4'd0 || c == 4'd8) return 1'b0;
    if (c == 4'd1) return a[16];
    if (c == 4'd9) return !a[16];
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sclk = 1'b0; si = b;
    @(negedge clk);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
  endtask

  // driver: predicts the outcome, pushes expectations, then drives the frame
  task automatic frame(input string tag, input int req, input int nfull,
                       input int extra, input logic busy_end);
    logic [7:0] op;
    logic [23:0] a;
    logic ok, clean, bsy;
    item_t e;
    op = tx[0];
    a = {tx[1], tx[2], tx[3]};
    clean = (extra == 0) && (nfull > 0);
    bsy = busy || busy_end;
    if (nfull >= 1 && (op == 8'h05 || op == 8'h9F))
      exp_q.push_back('{1'b1, op, 24'h0, '0, 8'h0, 8'(req)});
    if (nfull >= 4 && (op == 8'h03 || op == 8'h0B) && !busy)
      exp_q.push_back('{1'b1, op, a, '0, 8'h0, 8'(req)});
    ok = 1'b0;
    if (op == 8'h06 || op == 8'h04 || op == 8'hB9) ok = clean;
    else if (op == 8'hC7) ok = clean && m_wel && (bp == 4'd0 || bp == 4'd8);
    else if (op == 8'h01) ok = clean && nfull == 2 && m_wel;
    else if (op == 8'h02) ok = clean && nfull >= 5 && m_wel && !m_lock(bp, a);
    else if (op == 8'h20 || op == 8'h52 || op == 8'hD8)
      ok = clean && nfull == 4 && m_wel && !m_lock(bp, a);
    if (bsy) ok = 1'b0;
    if (ok) begin
      e.rd = 1'b0; e.op = op; e.req = 8'(req);
      e.addr = (op == 8'h02 || op == 8'h20 || op == 8'h52 || op == 8'hD8) ? a : 24'h0;
      e.nb = (op == 8'h02) ? CNT_W'(nfull - 4) : (op == 8'h01) ? CNT_W'(1) : '0;
      e.dat = tx[nfull-1];
      exp_q.push_back(e);
      if (op == 8'h06) m_wel = 1'b1;
      else if (op != 8'hB9) m_wel = 1'b0;
    end
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < nfull; i++)
      for (int j = 7; j >= 0; j--) send_bit(tx[i][j]);
    for (int j = 7; j > 7 - extra; j--) send_bit(tx[nfull][j]);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    if (busy_end) begin busy = 1'b1; @(negedge clk); busy = 1'b0; end
    repeat (6) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R%0d %s: actual missing strobe(s)=%0d expected 0", req, tag, exp_q.size());
      exp_q.delete();
    end
    chk($sformatf("R%0d %s wel", req, tag), wel, m_wel);
  endtask

  task automatic set4(input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3);
    tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = b3;
    for (int i = 4; i < 8; i++) tx[i] = 8'hA0 + 8'(i);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset wel", wel, 1'b0);
    chk("R11 reset strobe", cmd_valid | rd_req, 1'b0);

    set4(8'h06, 0, 0, 0); frame("R2 wren", 2, 1, 0, 0);
    set4(8'h04, 0, 0, 0); frame("R2 wrdi short", 2, 0, 5, 0);
    set4(8'h02, 8'h01, 8'h23, 8'h45); tx[4] = 8'h5A; tx[5] = 8'hC3;
    frame("R3 pp ok R1", 3, 6, 0, 0);
    frame("R8 pp no latch", 8, 6, 0, 0);
    set4(8'h06, 0, 0, 0); frame("R2 wren again", 2, 1, 0, 0);
    set4(8'h02, 8'h00, 8'h10, 8'h00); frame("R3 pp partial", 3, 5, 3, 0);
    frame("R3 pp no data", 3, 4, 0, 0);
    set4(8'h20, 8'h00, 8'h30, 8'h00); frame("R4 se long", 4, 5, 0, 0);
    frame("R4 se short", 4, 3, 0, 0);
    frame("R4 se ok", 4, 4, 0, 0);
    bp = 4'b0001;
    set4(8'h06, 0, 0, 0); frame("R8 wren", 8, 1, 0, 0);
    set4(8'hD8, 8'h01, 8'h00, 8'h00); frame("R6 upper locked", 6, 4, 0, 0);
    set4(8'h52, 8'h00, 8'hF0, 8'h00); frame("R6 lower free", 6, 4, 0, 0);
    bp = 4'b1001;
    set4(8'h06, 0, 0, 0); frame("R8 wren", 8, 1, 0, 0);
    set4(8'h20, 8'h00, 8'h00, 8'h00); frame("R6 lower locked", 6, 4, 0, 0);
    set4(8'h20, 8'h01, 8'hF0, 8'h00); frame("R6 upper free", 6, 4, 0, 0);
    bp = 4'b0101;
    set4(8'h06, 0, 0, 0); frame("R8 wren", 8, 1, 0, 0);
    set4(8'hC7, 0, 0, 0); frame("R7 ce locked", 7, 1, 0, 0);
    bp = 4'b1000;
    frame("R7 ce free", 7, 1, 0, 0);
    set4(8'h06, 0, 0, 0); frame("R8 wren", 8, 1, 0, 0);
    set4(8'h01, 8'h3C, 0, 0); frame("R5 wrsr long", 5, 3, 0, 0);
    frame("R5 wrsr", 5, 2, 0, 0);
    set4(8'h06, 0, 0, 0); frame("R9 wren busy edge", 9, 1, 0, 1);
    busy = 1'b1;
    frame("R9 wren busy", 9, 1, 0, 0);
    set4(8'h03, 8'h01, 8'h02, 8'h03); frame("R9 read busy", 9, 5, 0, 0);
    set4(8'h05, 0, 0, 0); frame("R9 rdsr busy", 9, 2, 0, 0);
    busy = 1'b0;
    set4(8'h0B, 8'h00, 8'hAB, 8'hCD); frame("R10 fast cut", 10, 5, 3, 0);
    set4(8'h9F, 0, 0, 0); frame("R10 rdid", 10, 1, 6, 0);
    set4(8'hB9, 0, 0, 0); frame("R2 dp", 2, 1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule